// File: doc/BRIEF.md
# Slave Transmit Byte Queue with Event-Driven Flush

This block holds the bytes that a bus controller sends while it acts as a slave transmitter. Software writes bytes into a small first-in, first-out store. The transmit shifter takes them out one at a time, in the order they were written. The block tracks how many bytes are held, reports when the store is empty or full, and tells the shifter when data may be used.

Four bus events empty the store on their own: a general-call match, a write-address match, a read-address match, and a NACK from the master. A configuration bit can switch off each of these separately. Every automatic flush locks the queue against software writes and raises a lockout interrupt, so that stale data cannot mix with a new transaction. Software can also request a flush by hand.

A preload mode lets software fill the queue before the address phase so the data survives the match. The block raises three interrupts: a level-threshold interrupt, an underflow interrupt when the master asks for data the queue does not hold, and the lockout interrupt.

Top module: `slave_tx_fifo`

## Requirements
- R1: Bytes accepted by `wrEn` appear on `shData` in write order. `shReq` removes the head byte when `empty` is 0. `level` gives the number of bytes held, and `empty` is 1 exactly when `level` is 0.
- R2: A write while `full` is 1 is dropped. `full` stays 1 and `level` stays at DEPTH.
- R3: With its disable bit clear, each bus event empties the queue one cycle after its pulse. The `cfgFlushDis` bit positions are: bit 0 general-call match (`gcMatch`), bit 1 write-address match (`wrMatch`), bit 2 read-address match (`rdMatch`), bit 3 master NACK (`mstNack`).
- R4: With the matching `cfgFlushDis` bit set, that event leaves `level` and the contents unchanged and does not raise `irqLock`.
- R5: Every automatic flush sets `irqLock`. While `irqLock` is 1, writes are ignored. A `lockClr` pulse clears the flag, and writes are accepted again after that. A manual flush does not set the flag.
- R6: `irqThresh` is 1 exactly when `level` is less than or equal to `thresh`.
- R7: `irqUnder` is set by a `firstBit` pulse that arrives while the queue is empty and no master NACK has been seen since the last address or general-call match. It stays set until `undClr`.
- R8: When `cfgPreload` is 1, the three match events do not flush the queue, and a master NACK still does. `preloadRdy` is 1 when `cfgPreload` is 1, the queue is not empty, and `irqLock` is 0.
- R9: When `cfgManualReady` is 0, `txReady` is 1 when the queue is not empty and `irqLock` is 0. When `cfgManualReady` is 1, `txReady` follows `swReadyIn`.
- R10: A `flushReq` pulse sets `flushPending` for exactly one cycle. At the end of that cycle the queue is empty and `flushPending` returns to 0. Writes in that cycle are lost.
- R11: After reset, `level` is 0, `empty` is 1, and `full`, `flushPending`, `irqLock` and `irqUnder` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgPreload | input | 1 | Preload mode: match events keep the contents |
| cfgManualReady | input | 1 | 1: software drives txReady |
| swReadyIn | input | 1 | Software value of txReady in manual mode |
| cfgFlushDis | input | 4 | Per-event auto-flush disables (see R3) |
| thresh | input | LVL_W | Threshold for irqThresh |
| wrEn | input | 1 | Software byte write strobe |
| wrData | input | DATA_W | Software write byte |
| flushReq | input | 1 | Manual flush request pulse |
| lockClr | input | 1 | Clears the lockout flag |
| undClr | input | 1 | Clears the underflow flag |
| shReq | input | 1 | Shifter takes the head byte |
| firstBit | input | 1 | Strobe at the first data bit of a byte |
| mstNack | input | 1 | Master returned NACK |
| gcMatch | input | 1 | General-call address match pulse |
| wrMatch | input | 1 | Write-address match pulse |
| rdMatch | input | 1 | Read-address match pulse |
| shData | output | DATA_W | Head byte for the shifter |
| level | output | LVL_W | Bytes held |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| flushPending | output | 1 | Manual flush in progress |
| txReady | output | 1 | Data may be used by the shifter |
| preloadRdy | output | 1 | Preloaded data is ready |
| irqThresh | output | 1 | Level at or below threshold |
| irqUnder | output | 1 | Underflow flag |
| irqLock | output | 1 | Lockout flag |

## Verification
A wrong pointer or count shows up at the ports on the next clock. `level` goes off, or `shData` shows a byte out of order the next time the bench looks at the head, so order is checked after every pop in a full drain. A wrong lockout or NACK-tracking bit cannot be seen directly. It shows only on a later stimulus: a write that should land and does not, or a `firstBit` that should set `irqUnder` and does not. For this reason the bench follows each event with a write or strobe within two cycles. Threshold, flush events and their disable bits are swept over every combination of a four-entry queue.

// File: rtl/slave_tx_fifo_pkg.sv
package slave_tx_fifo_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCmd_t;

  // Bit positions in the per-event flush-disable vector
  typedef enum logic [1:0] {
    EVT_GCALL   = 2'd0,
    EVT_WRMATCH = 2'd1,
    EVT_RDMATCH = 2'd2,
    EVT_NACK    = 2'd3
  } flushEvt_e;

  localparam int unsigned NUM_EVT = 4;

endpackage

// File: rtl/slave_tx_fifo_data.sv
module slave_tx_fifo_data
  import slave_tx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic [LVL_W-1:0]  count
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W-1:0]  wrPtrNext, rdPtrNext;

  // Wrap that works for any depth, not just powers of two
  assign wrPtrNext = (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
  assign rdPtrNext = (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;

  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.clear) begin
      store[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtrNext;
      if (cmd.pop)  rdPtr <= rdPtrNext;
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = store[rdPtr];

endmodule

// File: rtl/slave_tx_fifo_ctrl.sv
module slave_tx_fifo_ctrl
  import slave_tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgPreload,
  input  logic               cfgManualReady,
  input  logic               swReadyIn,
  input  logic [NUM_EVT-1:0] cfgFlushDis,
  input  logic [LVL_W-1:0]   thresh,
  input  logic               wrEn,
  input  logic               flushReq,
  input  logic               lockClr,
  input  logic               undClr,
  input  logic               shReq,
  input  logic               firstBit,
  input  logic               mstNack,
  input  logic               gcMatch,
  input  logic               wrMatch,
  input  logic               rdMatch,
  input  logic [LVL_W-1:0]   count,
  output fifoCmd_t           cmd,
  output logic               empty,
  output logic               full,
  output logic               flushPending,
  output logic               txReady,
  output logic               preloadRdy,
  output logic               irqThresh,
  output logic               irqUnder,
  output logic               irqLock
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [NUM_EVT-1:0] evtIn;
  logic [NUM_EVT-1:0] evtFire;
  logic               autoFlush;
  logic               anyMatch;
  logic               nackSeen;
  logic               underHit;

  assign evtIn[EVT_GCALL]   = gcMatch;
  assign evtIn[EVT_WRMATCH] = wrMatch;
  assign evtIn[EVT_RDMATCH] = rdMatch;
  assign evtIn[EVT_NACK]    = mstNack;

  // Per-event gating: the disable bit always applies; preload mode also
  // shields the contents from the three address-phase events.
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    if (g == int'(EVT_NACK)) begin : g_nack
      assign evtFire[g] = evtIn[g] & ~cfgFlushDis[g];
    end else begin : g_match
      assign evtFire[g] = evtIn[g] & ~cfgFlushDis[g] & ~cfgPreload;
    end
  end

  assign autoFlush = |evtFire;
  assign anyMatch  = gcMatch | wrMatch | rdMatch;

  assign empty = (count == '0);
  assign full  = (count == FULL_LVL);

  // Datapath strobes; a clear of either kind overrides push and pop
  always_comb begin
    cmd.clear = autoFlush | flushPending;
    cmd.push  = wrEn & ~full & ~irqLock & ~cmd.clear;
    cmd.pop   = shReq & ~empty & ~cmd.clear;
  end

  // Manual flush: visible for one cycle, then self-clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flushPending <= 1'b0;
    else        flushPending <= flushReq & ~flushPending;
  end

  // Lockout flag: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irqLock <= 1'b0;
    else if (autoFlush) irqLock <= 1'b1;
    else if (lockClr)   irqLock <= 1'b0;
  end

  // Tracks whether the master has ended the current read with a NACK
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        nackSeen <= 1'b0;
    else if (mstNack)  nackSeen <= 1'b1;
    else if (anyMatch) nackSeen <= 1'b0;
  end

  assign underHit = firstBit & empty & ~nackSeen & ~mstNack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irqUnder <= 1'b0;
    else if (underHit) irqUnder <= 1'b1;
    else if (undClr)   irqUnder <= 1'b0;
  end

  assign irqThresh  = (count <= thresh);
  assign preloadRdy = cfgPreload & ~empty & ~irqLock;
  assign txReady    = cfgManualReady ? swReadyIn : (~empty & ~irqLock);

endmodule

// File: rtl/slave_tx_fifo.sv
module slave_tx_fifo
  import slave_tx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgPreload,
  input  logic              cfgManualReady,
  input  logic              swReadyIn,
  input  logic [3:0]        cfgFlushDis,
  input  logic [LVL_W-1:0]  thresh,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flushReq,
  input  logic              lockClr,
  input  logic              undClr,
  input  logic              shReq,
  input  logic              firstBit,
  input  logic              mstNack,
  input  logic              gcMatch,
  input  logic              wrMatch,
  input  logic              rdMatch,
  output logic [DATA_W-1:0] shData,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              flushPending,
  output logic              txReady,
  output logic              preloadRdy,
  output logic              irqThresh,
  output logic              irqUnder,
  output logic              irqLock
);

  fifoCmd_t cmd;

  slave_tx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfgPreload     (cfgPreload),
    .cfgManualReady (cfgManualReady),
    .swReadyIn      (swReadyIn),
    .cfgFlushDis    (cfgFlushDis),
    .thresh         (thresh),
    .wrEn           (wrEn),
    .flushReq       (flushReq),
    .lockClr        (lockClr),
    .undClr         (undClr),
    .shReq          (shReq),
    .firstBit       (firstBit),
    .mstNack        (mstNack),
    .gcMatch        (gcMatch),
    .wrMatch        (wrMatch),
    .rdMatch        (rdMatch),
    .count          (level),
    .cmd            (cmd),
    .empty          (empty),
    .full           (full),
    .flushPending   (flushPending),
    .txReady        (txReady),
    .preloadRdy     (preloadRdy),
    .irqThresh      (irqThresh),
    .irqUnder       (irqUnder),
    .irqLock        (irqLock)
  );

  slave_tx_fifo_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .wrData   (wrData),
    .headData (shData),
    .count    (level)
  );

endmodule

// File: rtl/slave_tx_fifo_chk.sv
module slave_tx_fifo_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfgPreload,
  input logic [3:0]       cfgFlushDis,
  input logic             wrEn,
  input logic             flushReq,
  input logic             firstBit,
  input logic             rdMatch,
  input logic [LVL_W-1:0] level,
  input logic             empty,
  input logic             full,
  input logic             flushPending,
  input logic             irqUnder,
  input logic             irqLock
);

  // R2: occupancy never goes past the capacity
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R1: empty and full flags never both set
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R3: an enabled read-match flush leaves nothing behind and locks
  a_r3_rd_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (rdMatch && !cfgFlushDis[2] && !cfgPreload) |=> (level == '0) && irqLock);

  // R5: a locked queue never grows
  a_r5_locked_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (irqLock && wrEn) |=> level <= $past(level));

  // R10: manual flush pending lasts one cycle and ends empty
  a_r10_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    flushPending |=> !flushPending && (level == '0));

  a_r10_flush_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (flushReq && !flushPending) |=> flushPending);

  // R7: underflow only rises after a first-bit strobe on an empty queue
  a_r7_under_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqUnder) |-> ($past(firstBit) && $past(empty)));

endmodule

bind slave_tx_fifo slave_tx_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/test_slave_tx_fifo.sv
module test_slave_tx_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int DW = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgPreload = 0, cfgManualReady = 0, swReadyIn = 0;
  logic [3:0] cfgFlushDis = '0;
  logic [LW-1:0] thresh = '0;
  logic wrEn = 0, flushReq = 0, lockClr = 0, undClr = 0, shReq = 0;
  logic firstBit = 0, mstNack = 0, gcMatch = 0, wrMatch = 0, rdMatch = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] shData;
  logic [LW-1:0] level;
  logic empty, full, flushPending, txReady, preloadRdy;
  logic irqThresh, irqUnder, irqLock;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slave_tx_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_slave_tx_fifo (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pushByte(input logic [DW-1:0] b);
    wrEn = 1; wrData = b; tick(); wrEn = 0;
  endtask

  task automatic popByte();
    shReq = 1; tick(); shReq = 0;
  endtask

  task automatic doFlush();
    flushReq = 1; tick(); flushReq = 0; tick();
  endtask

  task automatic unlock();
    lockClr = 1; tick(); lockClr = 0;
  endtask

  task automatic pulseEvt(input int e);
    case (e)
      0: gcMatch = 1;
      1: wrMatch = 1;
      2: rdMatch = 1;
      default: mstNack = 1;
    endcase
    tick();
    gcMatch = 0; wrMatch = 0; rdMatch = 0; mstNack = 0;
  endtask

  task automatic clean();
    doFlush(); unlock();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chkEq("R11 level", int'(level), 0);
    chkEq("R11 empty", int'(empty), 1);
    chkEq("R11 full", int'(full), 0);
    chkEq("R11 flushPending", int'(flushPending), 0);
    chkEq("R11 irqLock", int'(irqLock), 0);
    chkEq("R11 irqUnder", int'(irqUnder), 0);
    rst_n = 1;
    tick();

    // R1/R2 fill past capacity, then drain in order
    for (int i = 0; i <= DEPTH; i++) begin
      pushByte(DW'(8'h30 + i));
      chkEq("R1 level while filling", int'(level), (i + 1 > DEPTH) ? DEPTH : i + 1);
    end
    chkEq("R2 full stays set", int'(full), 1);
    for (int i = 0; i < DEPTH; i++) begin
      chkEq("R1 head order", int'(shData), 8'h30 + i);
      popByte();
      chkEq("R1 level while draining", int'(level), DEPTH - 1 - i);
    end
    chkEq("R1 empty after drain", int'(empty), 1);
    popByte();
    chkEq("R1 pop on empty ignored", int'(level), 0);

    // R6 threshold sweep over every level and threshold
    for (int n = 0; n <= DEPTH; n++) begin
      clean();
      for (int k = 0; k < n; k++) pushByte(DW'(k));
      for (int th = 0; th <= DEPTH; th++) begin
        thresh = LW'(th);
        #1;
        chkEq("R6 threshold", int'(irqThresh), (n <= th) ? 1 : 0);
      end
    end
    thresh = '0;

    // R10 manual flush timing
    clean();
    for (int k = 0; k < 3; k++) pushByte(DW'(k));
    flushReq = 1; tick(); flushReq = 0;
    chkEq("R10 pending set", int'(flushPending), 1);
    chkEq("R10 level kept during pending", int'(level), 3);
    wrEn = 1; wrData = 8'h77; tick(); wrEn = 0;
    chkEq("R10 emptied", int'(level), 0);
    chkEq("R10 pending cleared", int'(flushPending), 0);
    chkEq("R5 manual flush does not lock", int'(irqLock), 0);

    // R3/R4/R5 every event with its disable bit clear and set
    for (int e = 0; e < 4; e++) begin
      for (int d = 0; d < 2; d++) begin
        cfgFlushDis = (d == 1) ? 4'(1 << e) : 4'h0;
        clean();
        pushByte(8'hA0); pushByte(8'hA1);
        pulseEvt(e);
        if (d == 0) begin
          chkEq("R3 auto flush level", int'(level), 0);
          chkEq("R5 lock raised", int'(irqLock), 1);
        end else begin
          chkEq("R4 disabled keeps level", int'(level), 2);
          chkEq("R4 disabled no lock", int'(irqLock), 0);
          chkEq("R4 disabled keeps head", int'(shData), 8'hA0);
        end
        pushByte(8'hB0);
        chkEq("R5 write while locked", int'(level), (d == 1) ? 3 : 0);
        unlock();
        pushByte(8'hB1);
        chkEq("R5 write after unlock", int'(level), (d == 1) ? 4 : 1);
      end
    end

    // R8 preload mode
    cfgFlushDis = 4'h0;
    clean();
    cfgPreload = 1;
    #1;
    chkEq("R8 preloadRdy empty", int'(preloadRdy), 0);
    pushByte(8'hC0); pushByte(8'hC1);
    chkEq("R8 preloadRdy filled", int'(preloadRdy), 1);
    pulseEvt(2);
    chkEq("R8 read match keeps data", int'(level), 2);
    pulseEvt(0);
    pulseEvt(1);
    chkEq("R8 matches keep data", int'(level), 2);
    chkEq("R8 no lock on match", int'(irqLock), 0);
    pulseEvt(3);
    chkEq("R8 nack still flushes", int'(level), 0);
    chkEq("R8 nack locks", int'(irqLock), 1);
    chkEq("R8 preloadRdy after lock", int'(preloadRdy), 0);
    cfgPreload = 0;

    // R7 underflow rule
    cfgFlushDis = 4'hF;
    clean();
    undClr = 1; tick(); undClr = 0;
    pulseEvt(2);
    firstBit = 1; tick(); firstBit = 0;
    chkEq("R7 underflow on empty", int'(irqUnder), 1);
    undClr = 1; tick(); undClr = 0;
    chkEq("R7 underflow cleared", int'(irqUnder), 0);
    pulseEvt(3);
    firstBit = 1; tick(); firstBit = 0;
    chkEq("R7 no underflow after nack", int'(irqUnder), 0);
    pulseEvt(2);
    pushByte(8'hD0);
    firstBit = 1; tick(); firstBit = 0;
    chkEq("R7 no underflow when data held", int'(irqUnder), 0);

    // R9 ready modes
    cfgFlushDis = 4'h0;
    clean();
    chkEq("R9 hw ready empty", int'(txReady), 0);
    pushByte(8'hE0);
    chkEq("R9 hw ready with data", int'(txReady), 1);
    pulseEvt(1);
    pushByte(8'hE1);
    chkEq("R9 hw ready when locked", int'(txReady), 0);
    cfgManualReady = 1; swReadyIn = 1;
    #1;
    chkEq("R9 manual ready high", int'(txReady), 1);
    swReadyIn = 0;
    #1;
    chkEq("R9 manual ready low", int'(txReady), 0);
    unlock();
    pushByte(8'hE2);
    chkEq("R9 manual ignores data", int'(txReady), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule